// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Inhibit Controls

This block is a small read cache that sits between a processor request port and an external bus controller. It holds 256 bytes as 16 lines. Each line has four 32-bit entries, and every entry has its own valid bit, so an entry can be filled or replaced without touching the other three. A read that finds its entry valid under a matching tag is answered from the cache with no bus activity.

A read that misses goes out on the bus. If the access may be cached, the block asks for a burst. The burst starts at the missed word and wraps within the line, and the requester gets that first word as soon as it arrives. When the bus controller answers with a single transfer only, just that one entry is filled. Writes always go out on the bus (write-through). A write updates the cache only if it hits, and a write miss allocates nothing.

Three controls decide whether the cache is used:
- A global disable input overrides the software enable.
- A per-transfer inhibit input from the bus controller keeps the data of that one beat out of the cache.
- A per-access inhibit attribute makes a missing access bypass the cache and drives the inhibit output on the bus.

A one-cycle invalidate input empties the whole cache.

Top module: `dm_read_cache`

## Requirements
- R1: A cacheable read that hits raises `cpu_ack` in the cycle after the request is sampled, with the cached word on `cpu_rdata`, and raises no `bus_req`.
- R2: A read miss with the cache on and `cpu_ci_attr` low raises `bus_req` with `bus_burst_req` high. The first beat address is the missed word (bits 3:2 = entry). Each following beat adds one to the entry field, modulo 4. The first beat's data is returned on `cpu_rdata`.
- R3: After a granted four-beat fill, a read of each of the four entries of that line hits with no bus transfer.
- R4: When `bus_burst_grant` is low on the first beat, the fill ends after one transfer. Only that entry becomes valid, and a read of another entry in the line misses.
- R5: A read miss with `cpu_ci_attr` high performs one transfer with `bus_ci_out` high and `bus_burst_req` low, and nothing is cached.
- R6: A beat returned with `bus_ci_in` high is not cached. On the first beat it also ends the fill. On a later beat of a burst, the other beats are still cached.
- R7: While `cache_disable` is high, reads go to the bus as single uncached transfers whatever `sw_enable` says. Contents cached before are kept.
- R8: While `sw_enable` is low, reads go to the bus as single uncached transfers.
- R9: A one-cycle pulse on `inval_all` clears every valid bit, so a following read of a previously cached word misses.
- R10: Every write makes one non-burst bus transfer with `bus_we` high. A write hit updates the cached word. A write miss allocates nothing.
- R11: During and after reset, `cpu_ack` and `bus_req` are low and every entry is invalid.
- R12: A read that hits is served from the cache even when `cpu_ci_attr` is high.
- R13: Filling an entry of a line under a new tag drops the old tag's entries of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_enable | input | 1 | Software cache enable |
| cache_disable | input | 1 | Global cache disable, overrides `sw_enable` |
| inval_all | input | 1 | Clear all valid bits in one cycle |
| cpu_req | input | 1 | Request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ci_attr | input | 1 | Translation cache-inhibit attribute of the access |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 32 | Word-aligned address of the current beat |
| bus_wdata | output | 32 | Bus write data |
| bus_burst_req | output | 1 | Asks for a wrapping line burst |
| bus_ci_out | output | 1 | Cache-inhibit output for the current transfer |
| bus_ack | input | 1 | Beat complete |
| bus_rdata | input | 32 | Beat read data |
| bus_burst_grant | input | 1 | Burst accepted, sampled with the first beat |
| bus_ci_in | input | 1 | Do not cache this beat |

## Verification
A wrong valid bit or tag shows up at the ports on the very next read of the affected word. A stale or lost bit turns an expected hit into a bus transfer, or turns a miss into a silent hit. Either way the per-access beat count reveals it one access later. A wrong wrap counter or wrong fill sequencing shows as a bad `bus_addr` on the second beat of a burst. A data entry written from the wrong beat returns a wrong word on the first later hit of that entry. The scenarios are chosen so that each inhibit path is followed at once by a read that tells a cached word from an uncached one.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSRD = 2'd1,
    ST_BUSWR = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES   = 16,
  parameter int ENTRIES = 4,
  parameter int TAGW    = 24,
  localparam int IDXW   = $clog2(LINES),
  localparam int ENTW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_all,
  input  logic [TAGW-1:0] lk_tag,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [ENTW-1:0] lk_ent,
  output logic            lk_hit,
  input  logic            fl_we,
  input  logic [TAGW-1:0] fl_tag,
  input  logic [IDXW-1:0] fl_idx,
  input  logic [ENTW-1:0] fl_ent
);
  logic [LINES-1:0][TAGW-1:0]    tag_q, tag_d;
  logic [LINES-1:0][ENTRIES-1:0] vld_q, vld_d;

  // next state: a fill under a new tag restarts the line's valid mask
  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (fl_we) begin
      if (tag_q[fl_idx] == fl_tag) begin
        vld_d[fl_idx][fl_ent] = 1'b1;
      end else begin
        tag_d[fl_idx]         = fl_tag;
        vld_d[fl_idx]         = '0;
        vld_d[fl_idx][fl_ent] = 1'b1;
      end
    end
    if (inv_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fl_we) tag_q <= tag_d;
  end

  assign lk_hit = vld_q[lk_idx][lk_ent] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TAGW    = 24,
  parameter int IDXW    = 4,
  parameter int ENTW    = 2,
  parameter int OFFW    = 2,
  localparam int ADRW   = TAGW + IDXW + ENTW + OFFW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cache_on,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [TAGW-1:0]      cpu_tag,
  input  logic [IDXW-1:0]      cpu_idx,
  input  logic [ENTW-1:0]      cpu_ent,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 cpu_ci_attr,
  input  logic                 lk_hit,
  input  logic [DW-1:0]        lk_data,
  output logic                 cpu_ack,
  output logic [DW-1:0]        cpu_rdata,
  input  logic                 bus_ack,
  input  logic [DW-1:0]        bus_rdata,
  input  logic                 bus_burst_grant,
  input  logic                 bus_ci_in,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [ADRW-1:0]      bus_addr,
  output logic [DW-1:0]        bus_wdata,
  output logic                 bus_burst_req,
  output logic                 bus_ci_out,
  output logic                 fl_we,
  output logic [TAGW-1:0]      fl_tag,
  output logic [IDXW-1:0]      fl_idx,
  output logic [ENTW-1:0]      fl_ent,
  output logic                 dw_en,
  output logic [IDXW+ENTW-1:0] dw_addr,
  output logic [DW-1:0]        dw_data
);
  localparam logic [ENTW-1:0] LAST_BEAT = '1;

  dmc_state_e    st_q, st_d;
  logic          ack_q, ack_d;
  logic          fill_q, fill_d;
  logic          attr_q, attr_d;
  logic [ENTW-1:0] cnt_q, cnt_d;
  logic [ENTW-1:0] ent_q, ent_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [TAGW-1:0] tag_q, tag_d;
  logic [DW-1:0]   wdata_q, wdata_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            keep_beat;
  logic            dp_en;

  always_comb begin
    st_d      = st_q;
    ack_d     = 1'b0;
    fill_d    = fill_q;
    attr_d    = attr_q;
    cnt_d     = cnt_q;
    ent_d     = ent_q;
    idx_d     = idx_q;
    tag_d     = tag_q;
    wdata_d   = wdata_q;
    rdata_d   = rdata_q;
    keep_beat = 1'b0;
    fl_we     = 1'b0;
    dw_en     = 1'b0;
    dw_addr   = {idx_q, ent_q};
    dw_data   = bus_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          tag_d   = cpu_tag;
          idx_d   = cpu_idx;
          ent_d   = cpu_ent;
          attr_d  = cpu_ci_attr;
          wdata_d = cpu_wdata;
          cnt_d   = '0;
          fill_d  = 1'b0;
          if (cpu_we) begin
            st_d = ST_BUSWR;
            if (cache_on && lk_hit) begin
              dw_en   = 1'b1;
              dw_addr = {cpu_idx, cpu_ent};
              dw_data = cpu_wdata;
            end
          end else if (cache_on && lk_hit) begin
            ack_d   = 1'b1;
            rdata_d = lk_data;
          end else begin
            st_d   = ST_BUSRD;
            fill_d = cache_on && !cpu_ci_attr;
          end
        end
      end
      ST_BUSRD: begin
        if (bus_ack) begin
          keep_beat = fill_q && !bus_ci_in;
          fl_we     = keep_beat;
          dw_en     = keep_beat;
          ent_d     = ent_q + 1'b1;
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q == '0) begin
            ack_d   = 1'b1;
            rdata_d = bus_rdata;
            if (!(keep_beat && bus_burst_grant)) st_d = ST_IDLE;
          end else if (cnt_q == LAST_BEAT) begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_BUSWR: begin
        if (bus_ack) begin
          ack_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  assign dp_en = (st_q == ST_IDLE && cpu_req) || bus_ack;

  always_ff @(posedge clk) begin
    if (dp_en) begin
      fill_q  <= fill_d;
      attr_q  <= attr_d;
      cnt_q   <= cnt_d;
      ent_q   <= ent_d;
      idx_q   <= idx_d;
      tag_q   <= tag_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_ack       = ack_q;
  assign cpu_rdata     = rdata_q;
  assign bus_req       = (st_q != ST_IDLE);
  assign bus_we        = (st_q == ST_BUSWR);
  assign bus_addr      = {tag_q, idx_q, ent_q, {OFFW{1'b0}}};
  assign bus_wdata     = wdata_q;
  assign bus_burst_req = (st_q == ST_BUSRD) && fill_q;
  assign bus_ci_out    = bus_req && attr_q;
  assign fl_tag        = tag_q;
  assign fl_idx        = idx_q;
  assign fl_ent        = ent_q;
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LINES   = 16,
  parameter int ENTRIES = 4,
  localparam int IDXW   = $clog2(LINES),
  localparam int ENTW   = $clog2(ENTRIES),
  localparam int OFFW   = $clog2(DW / 8),
  localparam int TAGW   = AW - IDXW - ENTW - OFFW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_enable,
  input  logic          cache_disable,
  input  logic          inval_all,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_ci_attr,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_burst_req,
  output logic          bus_ci_out,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_burst_grant,
  input  logic          bus_ci_in
);
  logic [1:0]            rst_sync_q;
  logic                  rst_i_n;
  logic                  cache_on;
  logic [TAGW-1:0]       cpu_tag;
  logic [IDXW-1:0]       cpu_idx;
  logic [ENTW-1:0]       cpu_ent;
  logic                  unused_offs;
  logic                  lk_hit;
  logic [DW-1:0]         lk_data;
  logic                  fl_we;
  logic [TAGW-1:0]       fl_tag;
  logic [IDXW-1:0]       fl_idx;
  logic [ENTW-1:0]       fl_ent;
  logic                  dw_en;
  logic [IDXW+ENTW-1:0]  dw_addr;
  logic [DW-1:0]         dw_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign cache_on    = sw_enable && !cache_disable;
  assign cpu_tag     = cpu_addr[AW-1 -: TAGW];
  assign cpu_idx     = cpu_addr[OFFW+ENTW +: IDXW];
  assign cpu_ent     = cpu_addr[OFFW +: ENTW];
  assign unused_offs = ^cpu_addr[OFFW-1:0];

  dmc_tag_store #(.LINES(LINES), .ENTRIES(ENTRIES), .TAGW(TAGW)) tags_i (
    .clk(clk), .rst_n(rst_i_n), .inv_all(inval_all),
    .lk_tag(cpu_tag), .lk_idx(cpu_idx), .lk_ent(cpu_ent), .lk_hit(lk_hit),
    .fl_we(fl_we), .fl_tag(fl_tag), .fl_idx(fl_idx), .fl_ent(fl_ent)
  );

  dmc_data_store #(.DEPTH(LINES * ENTRIES), .DW(DW)) data_i (
    .clk(clk), .we(dw_en), .waddr(dw_addr), .wdata(dw_data),
    .raddr({cpu_idx, cpu_ent}), .rdata(lk_data)
  );

  dmc_ctrl #(.DW(DW), .TAGW(TAGW), .IDXW(IDXW), .ENTW(ENTW), .OFFW(OFFW)) ctrl_i (
    .clk(clk), .rst_n(rst_i_n), .cache_on(cache_on),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
    .cpu_ent(cpu_ent), .cpu_wdata(cpu_wdata), .cpu_ci_attr(cpu_ci_attr),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_burst_grant(bus_burst_grant),
    .bus_ci_in(bus_ci_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_burst_req(bus_burst_req), .bus_ci_out(bus_ci_out),
    .fl_we(fl_we), .fl_tag(fl_tag), .fl_idx(fl_idx), .fl_ent(fl_ent),
    .dw_en(dw_en), .dw_addr(dw_addr), .dw_data(dw_data)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int AW   = 32,
  parameter int ENTW = 2,
  parameter int OFFW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cache_disable,
  input logic          cpu_ack,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_burst_req,
  input logic          bus_ci_out,
  input logic          bus_ack
);
  // R1: completion is a single-cycle pulse
  a_r1_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R5: inhibited transfers never ask for a burst and only accompany a request
  a_r5_ci_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ci_out |-> !bus_burst_req);
  a_r5_ci_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ci_out |-> bus_req);

  // R7: a transfer started while disabled is never a burst
  a_r7_disable_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && $past(cache_disable) |-> !bus_burst_req);

  // R10: writes are single transfers
  a_r10_write_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> !bus_burst_req);

  // R2: address holds until acknowledged, then steps by one entry with wrap
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> $stable(bus_addr));
  a_r2_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_burst_req && bus_ack |=>
      !bus_req || (bus_addr[OFFW +: ENTW] == ENTW'($past(bus_addr[OFFW +: ENTW]) + 1'b1)));
endmodule

bind dm_read_cache dmc_checker #(.AW(AW), .ENTW(ENTW), .OFFW(OFFW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cache_disable(cache_disable), .cpu_ack(cpu_ack),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_burst_req(bus_burst_req), .bus_ci_out(bus_ci_out), .bus_ack(bus_ack)
);

// File: tb/dm_read_cache_tb_top.sv
`timescale 1ns/1ps
module dm_read_cache_tb_top;
  logic        clk;
  logic        rst_n, sw_enable, cache_disable, inval_all;
  logic        cpu_req, cpu_we, cpu_ci_attr, cpu_ack;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        bus_req, bus_we, bus_burst_req, bus_ci_out;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ack, bus_burst_grant, bus_ci_in;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [31:0] exp_q[$];
  string       cur_req = "";
  bit          rd_pend = 0;
  int          nbeats = 0;
  int          ci_in_beat = -1;
  bit          grant = 1;
  logic [31:0] b_addr[8];
  bit          b_burst[8], b_ci[8], b_we[8];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dm_read_cache dut_i (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .cache_disable(cache_disable),
    .inval_all(inval_all), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ci_attr(cpu_ci_attr), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_burst_req(bus_burst_req), .bus_ci_out(bus_ci_out),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_burst_grant(bus_burst_grant),
    .bus_ci_in(bus_ci_in)
  );

  assign bus_burst_grant = grant;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus controller model: acknowledges every other cycle, logs each beat
  initial begin bus_ack = 1'b0; bus_ci_in = 1'b0; bus_rdata = '0; end
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_ack   = 1'b1;
      bus_rdata = memf(bus_addr);
      bus_ci_in = (nbeats == ci_in_beat);
      if (nbeats < 8) begin
        b_addr[nbeats]  = bus_addr;
        b_burst[nbeats] = bus_burst_req;
        b_ci[nbeats]    = bus_ci_out;
        b_we[nbeats]    = bus_we;
      end
      nbeats++;
    end else begin
      bus_ack   = 1'b0;
      bus_ci_in = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (cpu_ack && rd_pend) begin
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected ack"}, 32'd1, 32'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        chk(cpu_rdata == e, cur_req, cpu_rdata, e);
      end
    end
  end

  task automatic access(input string req, input logic [31:0] a, input bit we,
                        input logic [31:0] wd, input bit attr, input logic [31:0] ed,
                        input int eb, output int lat);
    cur_req = req;
    rd_pend = !we;
    if (!we) exp_q.push_back(ed);
    nbeats = 0;
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_ci_attr = attr; cpu_req = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 100);
    cpu_req = 1'b0;
    while (bus_req) @(negedge clk);
    @(negedge clk);
    chk(nbeats == eb, {req, " beat count"}, nbeats, eb);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    automatic int lat = 0;
    automatic logic [31:0] A = 32'h0000_1234;
    automatic logic [31:0] B = 32'h2000_0040;
    automatic logic [31:0] C = 32'h3000_0050;
    automatic logic [31:0] D = 32'h4000_0060;
    automatic logic [31:0] E = 32'h5000_0070;
    automatic logic [31:0] F = 32'h6000_0080;
    automatic logic [31:0] G = 32'h7000_1234;
    rst_n = 1'b0; sw_enable = 1'b1; cache_disable = 1'b0; inval_all = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_ci_attr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cpu_ack && !bus_req, "R11 outputs in reset", {cpu_ack, bus_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cpu_ack && !bus_req, "R11 outputs after reset", {cpu_ack, bus_req}, 0);

    access("R2 R11 first read misses", A, 0, 0, 0, memf(A), 4, lat);
    chk(b_burst[0], "R2 burst requested", b_burst[0], 1);
    chk(b_addr[0] == 32'h1234, "R2 beat0 addr", b_addr[0], 32'h1234);
    chk(b_addr[1] == 32'h1238, "R2 beat1 addr", b_addr[1], 32'h1238);
    chk(b_addr[2] == 32'h123C, "R2 beat2 addr", b_addr[2], 32'h123C);
    chk(b_addr[3] == 32'h1230, "R2 beat3 wrap addr", b_addr[3], 32'h1230);
    access("R3 hit entry0", 32'h1230, 0, 0, 0, memf(32'h1230), 0, lat);
    chk(lat == 1, "R1 hit latency", lat, 1);
    access("R3 hit entry2", 32'h1238, 0, 0, 0, memf(32'h1238), 0, lat);
    access("R3 hit entry3", 32'h123C, 0, 0, 0, memf(32'h123C), 0, lat);

    grant = 0;
    access("R4 single fill", B, 0, 0, 0, memf(B), 1, lat);
    access("R4 neighbour misses", B + 4, 0, 0, 0, memf(B + 4), 1, lat);
    access("R4 filled entry hits", B, 0, 0, 0, memf(B), 0, lat);
    grant = 1;

    access("R5 inhibited miss", C, 0, 0, 1, memf(C), 1, lat);
    chk(b_ci[0] && !b_burst[0], "R5 ci out without burst", {b_ci[0], b_burst[0]}, 2);
    access("R5 nothing cached", C, 0, 0, 0, memf(C), 4, lat);
    access("R12 hit ignores attribute", C, 0, 0, 1, memf(C), 0, lat);
    chk(lat == 1, "R12 hit latency", lat, 1);

    ci_in_beat = 0;
    access("R6 first beat inhibited", D, 0, 0, 0, memf(D), 1, lat);
    ci_in_beat = -1;
    access("R6 first beat not cached", D, 0, 0, 0, memf(D), 4, lat);
    ci_in_beat = 2;
    access("R6 burst with inhibited beat", E, 0, 0, 0, memf(E), 4, lat);
    ci_in_beat = -1;
    access("R6 other beat kept", E + 4, 0, 0, 0, memf(E + 4), 0, lat);
    access("R6 inhibited beat missing", E + 8, 0, 0, 0, memf(E + 8), 4, lat);

    cache_disable = 1'b1;
    access("R7 disabled read bypasses", A, 0, 0, 0, memf(A), 1, lat);
    chk(!b_burst[0], "R7 no burst when disabled", b_burst[0], 0);
    cache_disable = 1'b0;
    access("R7 contents kept", A, 0, 0, 0, memf(A), 0, lat);
    sw_enable = 1'b0;
    access("R8 software disabled bypasses", A, 0, 0, 0, memf(A), 1, lat);
    sw_enable = 1'b1;

    access("R10 write hit", A, 1, 32'hDEAD_BEEF, 0, 0, 1, lat);
    chk(b_we[0] && !b_burst[0] && b_addr[0] == A, "R10 write on bus", b_addr[0], A);
    access("R10 write hit updated", A, 0, 0, 0, 32'hDEAD_BEEF, 0, lat);
    access("R10 write miss", F, 1, 32'h1111_2222, 0, 0, 1, lat);
    access("R10 no allocate", F, 0, 0, 0, memf(F), 4, lat);

    access("R13 new tag fills line", G, 0, 0, 0, memf(G), 4, lat);
    access("R13 old tag displaced", A, 0, 0, 0, memf(A), 4, lat);

    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    access("R9 miss after invalidate", A, 0, 0, 0, memf(A), 4, lat);
    access("R9 refilled hits", A + 4, 0, 0, 0, memf(A + 4), 0, lat);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule